// File: doc/BRIEF.md
# Speculative Load Alias Tracker

This block keeps a small, fully associative record of loads that were moved ahead of possibly aliasing stores. When such an early load issues, the block stores an entry holding the load's destination register number and the 8-byte granule of the address it read. Every store presents its address to the table. Each valid entry whose granule matches the store is dropped, because its early value may now be stale.

Later, a check operation names a register and asks whether the early value is still trustworthy. A surviving entry means the value can be kept. A missing entry means the value must be fetched again (load-style check) or control must jump to recovery code (branch-style check). The answer arrives one cycle after the check is presented. A check sees any store and any clear-all in its own cycle, so a check may share a cycle with a store that aliases the early load. When every slot is taken, allocation reuses an entry already held by the same register first, then a free slot, and otherwise the least recently allocated slot. A single clear-all input empties the whole table in one cycle.

Top module: `altTable`

## Requirements
- R1: After reset the table holds no entries: no response is flagged until a check is presented, and a check of any register misses.
- R2: An allocation records its register and address granule. A later check of that register hits, and a hit leaves the entry in place, so a repeated check hits again.
- R3: A store invalidates every valid entry whose address agrees with the store address in all bits above bit 2, that is, any store within the same 8-byte granule. A store to a different granule leaves the entry intact.
- R4: The response to a check presented in cycle t appears in cycle t+1: respValid is 1 and exactly one of respHit, respReload or respRecover is 1. checkKind 0 (load-style) reports a miss on respReload. checkKind 1 (branch-style) reports a miss on respRecover. Without a check in cycle t, respValid is 0 in cycle t+1.
- R5: A check in the same cycle as a store to the granule of the checked entry misses.
- R6: An allocation in the same cycle as a store to the same granule leaves no valid entry for that register.
- R7: An allocation for a register that already has an entry replaces that entry. A later store to the old granule does not affect the register, and a store to the new granule does.
- R8: An allocation takes, in order of preference: the entry of the same register, the lowest-numbered free entry, and, when all are valid, the entry allocated least recently.
- R9: flushAll clears every entry in one cycle, including an allocation made in that cycle. A check in that cycle misses.
- R10: A check in the same cycle as an allocation for the same register sees the table as it was before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flushAll | input | 1 | Invalidate every entry |
| allocValid | input | 1 | Early load allocates an entry |
| allocReg | input | REG_W | Destination register of the early load |
| allocAddr | input | ADDR_W | Byte address read by the early load |
| storeValid | input | 1 | Store snoop valid |
| storeAddr | input | ADDR_W | Byte address written by the store |
| checkValid | input | 1 | Check request |
| checkKind | input | 1 | 0 load-style check, 1 branch-style check |
| checkReg | input | REG_W | Register being checked |
| respValid | output | 1 | Check response valid (one cycle after the check) |
| respHit | output | 1 | Entry still present, keep the early value |
| respReload | output | 1 | Load-style miss, reload from memory |
| respRecover | output | 1 | Branch-style miss, redirect to recovery |

## Verification
The bench builds the table with 4 entries, 3-bit register numbers and 8-bit addresses, and draws random addresses from only 8 granules. With these values the table fills after four allocations, so evicting the least recently allocated entry happens many times in a short run. Register numbers repeat often, which exercises replacement of an entry held by the same register, and stores frequently land in the same granule as a live entry, so they often invalidate one. Same-cycle collisions of store, allocation, check and clear-all also turn up often in the random phase, in addition to the directed cases.

// File: rtl/altPkg.sv
package altPkg;

  typedef enum logic {
    CHK_LOAD   = 1'b0,
    CHK_BRANCH = 1'b1
  } checkKind_e;

  typedef struct packed {
    logic flush;
    logic allocWe;
    logic allocSetValid;
  } altStrobes_t;

endpackage

// File: rtl/altEntries.sv
module altEntries
  import altPkg::*;
#(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int GRAN_W = 29,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  altStrobes_t       strobes,
  input  logic [IDX_W-1:0]  victimIdx,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [GRAN_W-1:0] allocGran,
  input  logic              storeValid,
  input  logic [GRAN_W-1:0] storeGran,
  input  logic [REG_W-1:0]  checkReg,
  output logic [N-1:0]      validVec,
  output logic [N-1:0]      allocRegHit,
  output logic [N-1:0]      storeHit,
  output logic [N-1:0]      checkRegHit,
  output logic [N-1:0]      oldestVec
);

  logic [N-1:0]      validQ;
  logic [REG_W-1:0]  regQ  [N];
  logic [GRAN_W-1:0] granQ [N];
  logic [IDX_W-1:0]  rankQ [N];
  logic [IDX_W-1:0]  victimRank;

  assign validVec   = validQ;
  assign victimRank = rankQ[victimIdx];

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign allocRegHit[i] = validQ[i] && (regQ[i] == allocReg);
    assign storeHit[i]    = storeValid && validQ[i] && (granQ[i] == storeGran);
    assign checkRegHit[i] = validQ[i] && (regQ[i] == checkReg);
    assign oldestVec[i]   = (rankQ[i] == IDX_W'(N - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < N; i++) begin
        regQ[i]  <= '0;
        granQ[i] <= '0;
        rankQ[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strobes.flush) begin
          validQ[i] <= 1'b0;
        end else if (strobes.allocWe && (victimIdx == IDX_W'(i))) begin
          validQ[i] <= strobes.allocSetValid;
        end else if (storeHit[i]) begin
          validQ[i] <= 1'b0;
        end
        if (strobes.allocWe && (victimIdx == IDX_W'(i))) begin
          regQ[i]  <= allocReg;
          granQ[i] <= allocGran;
          rankQ[i] <= '0;
        end else if (strobes.allocWe && (rankQ[i] < victimRank)) begin
          rankQ[i] <= rankQ[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/altCtrl.sv
module altCtrl
  import altPkg::*;
#(
  parameter int N      = 16,
  parameter int GRAN_W = 29,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              allocValid,
  input  logic [GRAN_W-1:0] allocGran,
  input  logic              storeValid,
  input  logic [GRAN_W-1:0] storeGran,
  input  logic              checkValid,
  input  logic              checkKind,
  input  logic [N-1:0]      validVec,
  input  logic [N-1:0]      allocRegHit,
  input  logic [N-1:0]      storeHit,
  input  logic [N-1:0]      checkRegHit,
  input  logic [N-1:0]      oldestVec,
  output altStrobes_t       strobes,
  output logic [IDX_W-1:0]  victimIdx,
  output logic              respValid,
  output logic              respHit,
  output logic              respReload,
  output logic              respRecover
);

  logic [IDX_W-1:0] sameIdx, freeIdx, oldIdx;
  logic             clash, hitNow;

  always_comb begin
    sameIdx = '0;
    freeIdx = '0;
    oldIdx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (allocRegHit[i]) sameIdx = IDX_W'(i);
      if (!validVec[i])   freeIdx = IDX_W'(i);
      if (oldestVec[i])   oldIdx  = IDX_W'(i);
    end
    if (|allocRegHit)      victimIdx = sameIdx;
    else if (!(&validVec)) victimIdx = freeIdx;
    else                   victimIdx = oldIdx;
  end

  assign clash  = storeValid && (allocGran == storeGran);
  assign hitNow = (|(checkRegHit & ~storeHit)) && !flushAll;

  always_comb begin
    strobes.flush         = flushAll;
    strobes.allocWe       = allocValid;
    strobes.allocSetValid = !clash && !flushAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respReload  <= 1'b0;
      respRecover <= 1'b0;
    end else begin
      respValid   <= checkValid;
      respHit     <= checkValid && hitNow;
      respReload  <= checkValid && !hitNow && (checkKind == CHK_LOAD);
      respRecover <= checkValid && !hitNow && (checkKind == CHK_BRANCH);
    end
  end

endmodule

// File: rtl/altTable.sv
module altTable
  import altPkg::*;
#(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              checkValid,
  input  logic              checkKind,
  input  logic [REG_W-1:0]  checkReg,
  output logic              respValid,
  output logic              respHit,
  output logic              respReload,
  output logic              respRecover
);

  localparam int IDX_W  = $clog2(N);
  localparam int GRAN_W = ADDR_W - OFFS_W;

  altStrobes_t       strobes;
  logic [IDX_W-1:0]  victimIdx;
  logic [GRAN_W-1:0] allocGran, storeGran;
  logic [N-1:0]      validVec, allocRegHit, storeHit, checkRegHit, oldestVec;
  logic              unusedLowBits;

  assign allocGran     = allocAddr[ADDR_W-1:OFFS_W];
  assign storeGran     = storeAddr[ADDR_W-1:OFFS_W];
  assign unusedLowBits = ^{allocAddr[OFFS_W-1:0], storeAddr[OFFS_W-1:0]};

  altEntries #(.N(N), .REG_W(REG_W), .GRAN_W(GRAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .victimIdx(victimIdx),
    .allocReg(allocReg), .allocGran(allocGran),
    .storeValid(storeValid), .storeGran(storeGran), .checkReg(checkReg),
    .validVec(validVec), .allocRegHit(allocRegHit), .storeHit(storeHit),
    .checkRegHit(checkRegHit), .oldestVec(oldestVec)
  );

  altCtrl #(.N(N), .GRAN_W(GRAN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll),
    .allocValid(allocValid), .allocGran(allocGran),
    .storeValid(storeValid), .storeGran(storeGran),
    .checkValid(checkValid), .checkKind(checkKind),
    .validVec(validVec), .allocRegHit(allocRegHit), .storeHit(storeHit),
    .checkRegHit(checkRegHit), .oldestVec(oldestVec),
    .strobes(strobes), .victimIdx(victimIdx),
    .respValid(respValid), .respHit(respHit),
    .respReload(respReload), .respRecover(respRecover)
  );

endmodule

// File: rtl/altChecker.sv
module altChecker #(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushAll,
  input logic              allocValid,
  input logic [REG_W-1:0]  allocReg,
  input logic [ADDR_W-1:0] allocAddr,
  input logic              storeValid,
  input logic [ADDR_W-1:0] storeAddr,
  input logic              checkValid,
  input logic              checkKind,
  input logic [REG_W-1:0]  checkReg,
  input logic              respValid,
  input logic              respHit,
  input logic              respReload,
  input logic              respRecover
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !respValid);

  p_resp_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> respValid);

  p_no_stray_resp_r4: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !respValid && !respHit && !respReload && !respRecover);

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respHit, respReload, respRecover}) == 1);

  p_load_kind_r4: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && !checkKind |=> !respRecover);

  p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && flushAll |=> !respHit);

  p_alloc_then_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(allocValid) && !$past(storeValid) && !$past(flushAll) &&
     checkValid && checkReg == $past(allocReg) && !storeValid && !flushAll)
    |=> respHit);

  p_clash_invalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(allocValid) && $past(storeValid) &&
     $past(allocAddr[ADDR_W-1:OFFS_W]) == $past(storeAddr[ADDR_W-1:OFFS_W]) &&
     checkValid && checkReg == $past(allocReg))
    |=> !respHit);

endmodule

bind altTable altChecker #(.REG_W(REG_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .flushAll(flushAll),
  .allocValid(allocValid), .allocReg(allocReg), .allocAddr(allocAddr),
  .storeValid(storeValid), .storeAddr(storeAddr),
  .checkValid(checkValid), .checkKind(checkKind), .checkReg(checkReg),
  .respValid(respValid), .respHit(respHit),
  .respReload(respReload), .respRecover(respRecover)
);

// File: tb/altTable_bench.sv
module altTable_bench;

  localparam int N      = 4;
  localparam int REG_W  = 3;
  localparam int ADDR_W = 8;
  localparam int OFFS_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushAll = 1'b0, allocValid = 1'b0, storeValid = 1'b0, checkValid = 1'b0, checkKind = 1'b0;
  logic [REG_W-1:0]  allocReg = '0, checkReg = '0;
  logic [ADDR_W-1:0] allocAddr = '0, storeAddr = '0;
  logic respValid, respHit, respReload, respRecover;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int mValid [N];
  int mReg   [N];
  int mGran  [N];
  int mRank  [N];

  always #10 clk = ~clk;

  altTable #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_altTable (
    .clk(clk), .rstN(rstN), .flushAll(flushAll),
    .allocValid(allocValid), .allocReg(allocReg), .allocAddr(allocAddr),
    .storeValid(storeValid), .storeAddr(storeAddr),
    .checkValid(checkValid), .checkKind(checkKind), .checkReg(checkReg),
    .respValid(respValid), .respHit(respHit),
    .respReload(respReload), .respRecover(respRecover)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int modelHit(int creg, bit sv, int saddr, bit fl);
    if (fl) return 0;
    for (int i = 0; i < N; i++)
      if (mValid[i] != 0 && mReg[i] == creg && !(sv && mGran[i] == (saddr >> OFFS_W)))
        return 1;
    return 0;
  endfunction

  function automatic int modelVictim(int areg);
    for (int i = 0; i < N; i++) if (mValid[i] != 0 && mReg[i] == areg) return i;
    for (int i = 0; i < N; i++) if (mValid[i] == 0) return i;
    for (int i = 0; i < N; i++) if (mRank[i] == N - 1) return i;
    return 0;
  endfunction

  task automatic modelUpdate(bit av, int areg, int aaddr, bit sv, int saddr, bit fl);
    int v, vr;
    int sg, ag;
    sg = saddr >> OFFS_W;
    ag = aaddr >> OFFS_W;
    v  = av ? modelVictim(areg) : -1;
    vr = av ? mRank[v] : 0;
    for (int i = 0; i < N; i++) begin
      if (fl) mValid[i] = 0;
      else if (i == v) mValid[i] = (sv && ag == sg) ? 0 : 1;
      else if (sv && mValid[i] != 0 && mGran[i] == sg) mValid[i] = 0;
      if (i == v) begin
        mReg[i] = areg; mGran[i] = ag; mRank[i] = 0;
      end else if (av && mRank[i] < vr) begin
        mRank[i] = mRank[i] + 1;
      end
    end
  endtask

  task automatic step(string tag, bit av, int areg, int aaddr, bit sv, int saddr,
                      bit cv, bit ck, int creg, bit fl);
    int eh;
    @(negedge clk);
    allocValid = av; allocReg = REG_W'(areg); allocAddr = ADDR_W'(aaddr);
    storeValid = sv; storeAddr = ADDR_W'(saddr);
    checkValid = cv; checkKind = ck; checkReg = REG_W'(creg);
    flushAll = fl;
    eh = cv ? modelHit(creg, sv, saddr, fl) : 0;
    modelUpdate(av, areg, aaddr, sv, saddr, fl);
    @(posedge clk);
    #1;
    chk(tag, "respValid", int'(respValid), int'(cv));
    if (cv) begin
      chk(tag, "respHit", int'(respHit), eh);
      chk(tag, "respReload", int'(respReload), (!eh && !ck) ? 1 : 0);
      chk(tag, "respRecover", int'(respRecover), (!eh && ck) ? 1 : 0);
    end
  endtask

  task automatic probe(string tag, int creg, bit ck);
    step(tag, 0, 0, 0, 0, 0, 1, ck, creg, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mReg[i] = 0; mGran[i] = 0; mRank[i] = i;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "respValid in reset", int'(respValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 8; r++) probe("R1", r, 0);

    step("R2", 1, 1, 'h10, 0, 0, 0, 0, 0, 0);
    probe("R2", 1, 0);
    probe("R2", 1, 1);
    step("R3", 0, 0, 0, 1, 'h17, 0, 0, 0, 0);
    probe("R3", 1, 0);
    probe("R4", 1, 1);
    step("R3", 1, 1, 'h10, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 'h18, 0, 0, 0, 0);
    probe("R3", 1, 0);
    probe("R4", 2, 1);
    probe("R4", 2, 0);
    step("R5", 0, 0, 0, 1, 'h12, 1, 0, 1, 0);
    probe("R5", 1, 0);
    step("R6", 1, 2, 'h20, 1, 'h23, 0, 0, 0, 0);
    probe("R6", 2, 0);
    step("R7", 1, 3, 'h30, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 3, 'h40, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 'h30, 0, 0, 0, 0);
    probe("R7", 3, 0);
    step("R7", 0, 0, 0, 1, 'h44, 0, 0, 0, 0);
    probe("R7", 3, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int r = 0; r < 4; r++) step("R8", 1, r, 'h80 + 8 * r, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 4, 'hc0, 0, 0, 0, 0, 0, 0);
    probe("R8", 0, 0);
    probe("R8", 1, 0);
    step("R8", 0, 0, 0, 1, 'h90, 0, 0, 0, 0);
    step("R8", 1, 5, 'hc8, 0, 0, 0, 0, 0, 0);
    probe("R8", 1, 0);
    probe("R8", 3, 0);
    probe("R8", 5, 0);
    step("R9", 1, 6, 'h50, 0, 0, 1, 0, 1, 1);
    probe("R9", 1, 0);
    probe("R9", 6, 1);
    step("R10", 1, 7, 'h58, 0, 0, 1, 0, 7, 0);
    probe("R10", 7, 0);

    for (int n = 0; n < 3000; n++) begin
      bit av, sv, cv, ck, fl;
      av = ($urandom % 100) < 50;
      sv = ($urandom % 100) < 30;
      cv = ($urandom % 100) < 60;
      ck = $urandom % 2;
      fl = ($urandom % 100) < 2;
      step("R2/R3/R8 random", av, $urandom % 8, $urandom % 64, sv, $urandom % 64,
           cv, ck, $urandom % 8, fl);
    end
    finish();
  end

endmodule